// File: doc/BRIEF.md
# Burst-of-Two Separate-Port Synchronous SRAM

This block is a synchronous memory with a read port and a write port that work independently. Each request names an index rather than a word: the index selects a pair of adjacent words, and every access moves both words as two beats on consecutive clock cycles. The word-address low bit never appears at the ports. The block forces it to 0 for the first beat and to 1 for the second. The index field is therefore one bit narrower than the word address.

Write data and byte-lane enables arrive one beat per cycle after the write request. Each 9-bit lane is written only when its enable is set in that same beat. Reads are pipelined, and read data returns a fixed number of cycles after the request, with a valid flag on each beat. Writes still in flight are visible to later reads. A read accepted in the same cycle as a write to the same index, or any cycle after it, returns the new bytes merged over the old ones.

The design uses one fast clock in which each clock cycle carries one beat. This stands in for a double-rate interface whose output registers are timed from the input clock.

Top module: `sqb2_sram`

## Requirements
- R1: A read request and a write request presented in the same cycle are both accepted, and each completes its own transfer.
- R2: Every accepted read produces exactly two output beats on consecutive cycles with rd_valid high. An isolated read therefore shows rd_valid high for exactly two cycles.
- R3: The first beat of an access to index I addresses word 2*I. The second beat addresses word 2*I+1.
- R4: For a write accepted in cycle t, wr_data and wr_be are sampled in cycle t+1 for word 2*I and in cycle t+2 for word 2*I+1. Lane n covers bits [9n+8:9n] and is written only when wr_be[n] is 1 in that beat. Data and enables presented in any other cycle change nothing.
- R5: For a read accepted in cycle t, word 2*I appears on rd_data in cycle t+RD_LAT and word 2*I+1 in cycle t+RD_LAT+1. RD_LAT is at least 2.
- R6: A read accepted in the same cycle as a write to the same index, or 1, 2 or more cycles later, returns the written bytes merged with the older contents of the disabled lanes. A read accepted before such a write returns the older contents.
- R7: A read request in the cycle right after an accepted read is ignored. The same holds for a write request in the cycle right after an accepted write. A request in the cycle after that is accepted.
- R8: After reset, and in every cycle where rd_valid is 0, rd_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; one data beat per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request |
| rd_idx | input | AW-1 | Read index (word address without its low bit) |
| wr_req | input | 1 | Write request |
| wr_idx | input | AW-1 | Write index |
| wr_data | input | DATA_W | Write data beat |
| wr_be | input | DATA_W/9 | Per-lane write enables, sampled with each data beat |
| rd_data | output | DATA_W | Read data beat |
| rd_valid | output | 1 | High in each cycle that carries a read beat |

## Verification
Assertions check several properties on every cycle:
- Each burst starts on the even word and follows it with the odd word of the loaded index.
- A request during a first beat never restarts a sequencer.
- Every written beat enters the pending-write stage.
- The pending and incoming write beats never target the same word.
- A fully enabled incoming beat overrides the fetched word.
- Output bursts last at least two beats.
- rd_data is zero whenever rd_valid is low.

Only the bench's scenarios can show the rest:
- The exact return cycle of each beat.
- Byte merging against memory contents.
- Read-before-write ordering.
- Coherency at distances 0, 1 and 2.
- That data driven outside write beats leaves memory untouched.

// File: rtl/sqb2_pkg.sv
// Shared definitions for the burst-of-two SRAM.
// Assumes data words are built from whole 9-bit byte lanes.
package sqb2_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sqb2_burst_seq.sv
// Burst sequencer: turns an index request into two beats on the next two
// cycles, supplying the word address with the low bit 0 then 1.
// Assumes a request is only acceptable when the next cycle is free, so a
// request arriving during the first beat is dropped.
module sqb2_burst_seq
    import sqb2_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [IW-1:0] idx,
    output logic          accept,
    output logic          act,
    output logic [IW:0]   word
);

    seq_state_e    st_q;
    logic [IW-1:0] idx_q;

    // A new burst may start unless the coming cycle belongs to the second beat.
    assign accept = req && (st_q != SEQ_FIRST);

    // Advance the beat state and capture the index on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            idx_q <= '0;
        end else if (accept) begin
            st_q  <= SEQ_FIRST;
            idx_q <= idx;
        end else if (st_q == SEQ_FIRST) begin
            st_q  <= SEQ_SECOND;
        end else begin
            st_q  <= SEQ_IDLE;
        end
    end

    // Word address for the current beat: index with generated low bit.
    assign act  = (st_q != SEQ_IDLE);
    assign word = {idx_q, (st_q == SEQ_SECOND)};

    AST_FIRST_THEN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !word[0]) |=> (act && word[0]));  // R2

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (act && !word[0] && word[IW:1] == $past(idx)));  // R3

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (req && act && !word[0]) |=> (act && word[0]));  // R7

endmodule

// File: rtl/sqb2_store.sv
// Word store with a one-entry pending-write stage.
// An incoming write beat is held in the stage for one cycle and committed to
// the array on the following edge. The fetch port merges, lane by lane, the
// array word, then the staged beat, then the incoming beat (newest wins),
// so reads see writes that have not reached the array yet.
// Assumes DW is a whole number of 9-bit lanes; the array itself is not reset.
module sqb2_store
    import sqb2_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int NB    = DW / LANE_W,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_act,
    input  logic [AW-1:0] wr_word,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_be,
    input  logic [AW-1:0] fetch_word,
    output logic [DW-1:0] fetch_data
);

    logic [DW-1:0] mem_q [DEPTH];
    logic          stg_vld;
    logic [AW-1:0] stg_word;
    logic [DW-1:0] stg_data;
    logic [NB-1:0] stg_be;
    logic          stg_hit;
    logic          live_hit;

    // Hold the current write beat for one cycle as the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_word <= '0;
            stg_data <= '0;
            stg_be   <= '0;
        end else begin
            stg_vld  <= wr_act;
            stg_word <= wr_word;
            stg_data <= wr_data;
            stg_be   <= wr_be;
        end
    end

    // Commit the pending write into the array, lane by lane.
    always_ff @(posedge clk) begin
        if (stg_vld) begin
            for (int l = 0; l < NB; l++) begin
                if (stg_be[l]) begin
                    mem_q[stg_word][l*LANE_W +: LANE_W] <= stg_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign stg_hit  = stg_vld && (stg_word == fetch_word);
    assign live_hit = wr_act && (wr_word == fetch_word);

    for (genvar l = 0; l < NB; l++) begin : g_lane
        logic [LANE_W-1:0] lane_v;

        // Pick the newest copy of this lane among array, stage and live beat.
        always_comb begin
            lane_v = mem_q[fetch_word][l*LANE_W +: LANE_W];
            if (stg_hit && stg_be[l]) begin
                lane_v = stg_data[l*LANE_W +: LANE_W];
            end
            if (live_hit && wr_be[l]) begin
                lane_v = wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign fetch_data[l*LANE_W +: LANE_W] = lane_v;
    end

    AST_STAGE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> (stg_vld && stg_word == $past(wr_word)));  // R4

    AST_STAGE_LIVE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && wr_act) |-> (stg_word != wr_word));  // R3

    AST_LIVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && wr_word == fetch_word && wr_be == {NB{1'b1}}) |-> (fetch_data == wr_data));  // R6

endmodule

// File: rtl/sqb2_rd_pipe.sv
// Read return pipeline: registers fetched beats and delays them so that the
// first beat leaves RD_LAT cycles after its request. Data is forced to zero
// on beats that carry nothing.
// Assumes RD_LAT >= 2 (one cycle is spent before the fetch).
module sqb2_rd_pipe #(
    parameter int DW     = 18,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);

    localparam int STG = RD_LAT - 1;

    logic [STG-1:0] vld_q;
    logic [DW-1:0]  dat_q [STG];

    // First stage: capture the fetched beat, zeroing empty cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            dat_q[0] <= in_vld ? in_data : '0;
        end
    end

    for (genvar s = 1; s < STG; s++) begin : g_delay
        // Extra latency stage: shift the beat one cycle further.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    assign out_vld  = vld_q[STG-1];
    assign out_data = dat_q[STG-1];

    AST_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |=> out_vld);  // R2

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_data == '0));  // R8

endmodule

// File: rtl/sqb2_sram.sv
// Burst-of-two SRAM with separate read and write ports.
// Each request carries an index. Two sequencers expand requests into two
// beats. Write beats go through the store's pending stage into the array.
// Read beats fetch a coherent merged word that the return pipeline delays.
// Assumes one clock cycle per beat and DATA_W a multiple of 9.
module sqb2_sram
    import sqb2_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int WORD_DEPTH = 256,
    parameter int RD_LAT     = 2,
    localparam int NB        = DATA_W / LANE_W,
    localparam int AW        = $clog2(WORD_DEPTH),
    localparam int IW        = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IW-1:0]     rd_idx,
    input  logic              wr_req,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              rd_acc;
    logic              rd_act;
    logic [AW-1:0]     rd_word;
    logic              wr_acc;
    logic              wr_act;
    logic [AW-1:0]     wr_word;
    logic [DATA_W-1:0] fetch_data;

    sqb2_burst_seq #(.IW(IW)) i_rd_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rd_req),
        .idx    (rd_idx),
        .accept (rd_acc),
        .act    (rd_act),
        .word   (rd_word)
    );

    sqb2_burst_seq #(.IW(IW)) i_wr_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wr_req),
        .idx    (wr_idx),
        .accept (wr_acc),
        .act    (wr_act),
        .word   (wr_word)
    );

    sqb2_store #(
        .DW    (DATA_W),
        .DEPTH (WORD_DEPTH),
        .NB    (NB),
        .AW    (AW)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_act     (wr_act),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .fetch_word (rd_word),
        .fetch_data (fetch_data)
    );

    sqb2_rd_pipe #(
        .DW     (DATA_W),
        .RD_LAT (RD_LAT)
    ) i_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_act),
        .in_data  (fetch_data),
        .out_vld  (rd_valid),
        .out_data (rd_data)
    );

    AST_BOTH_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && wr_acc) |=> (rd_act && wr_act));  // R1

endmodule

// File: tb/test_sqb2_sram.sv
`timescale 1ns/1ps
module test_sqb2_sram;

    localparam int DW    = 18;
    localparam int DEPTH = 256;
    localparam int LAT   = 2;
    localparam int LW    = 9;
    localparam int NB    = DW / LW;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = AW - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_req;
    logic [IW-1:0] rd_idx;
    logic          wr_req;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic [NB-1:0] wr_be;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    sqb2_sram #(.DATA_W(DW), .WORD_DEPTH(DEPTH), .RD_LAT(LAT)) i_sqb2_sram (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .wr_req   (wr_req),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    bit be_all = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    int            w_ph = 0;
    int            r_ph = 0;
    logic [IW-1:0] w_ix = '0;
    logic [IW-1:0] r_ix = '0;
    string         r_tag = "R5";
    logic          exp_v [64];
    logic [DW-1:0] exp_d [64];
    string         exp_t [64];

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int l = 0; l < NB; l++) begin
            if (be[l]) r[l*LW +: LW] = d[l*LW +: LW];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // One beat cycle: drive inputs, update the reference model, check outputs.
    task automatic step(bit rq, logic [IW-1:0] ri, bit wq, logic [IW-1:0] wi, string tag);
        logic [DW-1:0] d;
        logic [NB-1:0] be;
        int slot;
        int fs;
        d  = DW'($urandom);
        be = be_all ? '1 : NB'($urandom);
        wr_data = d;
        wr_be   = be;
        if (w_ph != 0) begin
            ref_mem[{w_ix, w_ph == 2}] = merge(ref_mem[{w_ix, w_ph == 2}], d, be);
        end
        if (r_ph != 0) begin
            fs = (cyc + LAT - 1) % 64;
            exp_v[fs] = 1'b1;
            exp_d[fs] = ref_mem[{r_ix, r_ph == 2}];
            exp_t[fs] = r_tag;
        end
        if (wq && w_ph != 1) begin
            w_ph = 1;
            w_ix = wi;
        end else begin
            w_ph = (w_ph == 1) ? 2 : 0;
        end
        if (rq && r_ph != 1) begin
            r_ph  = 1;
            r_ix  = ri;
            r_tag = tag;
        end else begin
            r_ph = (r_ph == 1) ? 2 : 0;
        end
        rd_req = rq;
        rd_idx = ri;
        wr_req = wq;
        wr_idx = wi;
        slot = cyc % 64;
        if (exp_v[slot]) check(exp_t[slot], {rd_valid, rd_data}, {1'b1, exp_d[slot]});
        else             check("R8", {rd_valid, rd_data}, '0);
        exp_v[slot] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, "R8");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog expired, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst_n = 1'b0; rd_req = 0; wr_req = 0; rd_idx = '0; wr_idx = '0;
        wr_data = '0; wr_be = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", {rd_valid, rd_data}, '0);
        rst_n = 1'b1;

        // Fill every word with full lanes so the array contents are known (R4).
        be_all = 1;
        for (int i = 0; i < DEPTH / 2; i++) begin
            step(0, '0, 1, IW'(i), "R4");
            step(0, '0, 0, '0, "R4");
        end
        be_all = 0;
        idle(3);

        // Read back every index; beat order and timing (R3, R5).
        for (int i = 0; i < DEPTH / 2; i++) begin
            step(1, IW'(i), 0, '0, "R3");
            step(0, '0, 0, '0, "R5");
        end
        idle(3);

        // Read and write in the same cycle on different indexes (R1).
        step(1, 7'd5, 1, 7'd9, "R1");
        idle(3);
        step(1, 7'd9, 0, '0, "R1");
        idle(4);

        // Coherency at distances 0, 1 and 2, and read before write (R6).
        step(1, 7'd20, 1, 7'd20, "R6");
        idle(4);
        step(0, '0, 1, 7'd21, "R6");
        step(1, 7'd21, 0, '0, "R6");
        idle(4);
        step(0, '0, 1, 7'd22, "R6");
        step(0, '0, 0, '0, "R6");
        step(1, 7'd22, 0, '0, "R6");
        idle(4);
        step(1, 7'd23, 0, '0, "R6");
        step(0, '0, 1, 7'd23, "R6");
        idle(3);
        step(1, 7'd23, 0, '0, "R6");
        idle(4);

        // Requests in the cycle after an accepted one are dropped (R7).
        step(0, '0, 1, 7'd30, "R7");
        step(1, 7'd40, 1, 7'd31, "R7");
        step(1, 7'd41, 0, '0, "R7");
        idle(4);
        step(1, 7'd31, 0, '0, "R7");
        idle(4);

        // Continuous requests: reads stream every other cycle (R2).
        for (int i = 0; i < 12; i++) step(1, IW'(i), 1, IW'(i + 3), "R2");
        idle(4);

        // Random mix over a few indexes to provoke collisions (R6).
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, IW'($urandom % 8),
                 ($urandom % 3) == 0, IW'($urandom % 8), "R6");
        end
        idle(6);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule